// File: doc/BRIEF.md
# Masked Alarm Match Interrupt Unit

This unit watches the running calendar time of a real-time clock and raises an alarm when the time matches a programmed alarm. The time arrives as six BCD fields: second, minute, hour, date, month and weekday. The alarm is held in six alarm registers, one per field. Bit 7 of each alarm register is that field's enable. Only enabled fields take part in the comparison. Leaving the other fields disabled makes the alarm recur, so one enabled second field gives one alarm per minute.

The comparison runs only on the cycle that carries the once-per-second tick, so each matching second gives exactly one event. The alarm has two modes:

- **Latched mode:** an event sets a status flag and holds the active-low interrupt line low until software clears the flag.
- **Pulsed mode:** every event sets the flag and drives the interrupt line low for a fixed number of slow-clock enables. The default is 8192 enables of a 32768 Hz strobe, which is 250 ms.

A global enable gates all alarm activity. Selecting a nonzero frequency-output code also shuts the alarm out. Software can only clear the flag, never set it. When auto-reset is on, a completed status read also clears the flag, unless an alarm fired while that read was in progress.

Top module: `alarm_match_irq`

## Requirements
- R1: Bit 7 of each alarm register enables that field. An enabled field matches when its bits [6:0] equal bits [6:0] of the current-time field. Disabled fields never block a match.
- R2: When no alarm register has bit 7 set, no alarm event is ever generated.
- R3: A match is evaluated only in a cycle where `tick_1hz` is 1. `alarm_flag` is 1 after the rising edge that samples that tick. Without the tick, nothing is set.
- R4: While `alm_enable` is 0, no alarm event is generated.
- R5: While `freq_sel` is nonzero, no alarm event is generated.
- R6: In latched mode (`pulse_mode` = 0), `irq_n` goes low one cycle after `alarm_flag` rises. It stays low while the flag is 1 and returns high one cycle after the flag clears.
- R7: In pulsed mode (`pulse_mode` = 1), each event sets `alarm_flag`. Starting one cycle after the event, `irq_n` is low for exactly PULSE_TICKS asserted `tick_32k` cycles. Every later matching tick produces a new pulse.
- R8: A one-cycle `clr_req` clears `alarm_flag`. An event in the same cycle wins, and the flag stays 1. No input can set the flag other than an alarm event.
- R9: A one-cycle `rd_done` clears `alarm_flag` when `auto_clr` is 1 and has no effect when `auto_clr` is 0.
- R10: If an event occurs while `rd_busy` is 1, or in the `rd_done` cycle, the flag remains 1 after that `rd_done`, even with `auto_clr` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe on each second boundary |
| tick_32k | input | 1 | 32768 Hz enable strobe for pulse timing |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_date | input | 8 | Current date, BCD |
| cur_month | input | 8 | Current month, BCD |
| cur_wday | input | 8 | Current weekday |
| al_sec | input | 8 | Seconds alarm, bit 7 enable |
| al_min | input | 8 | Minutes alarm, bit 7 enable |
| al_hour | input | 8 | Hour alarm, bit 7 enable |
| al_date | input | 8 | Date alarm, bit 7 enable |
| al_month | input | 8 | Month alarm, bit 7 enable |
| al_wday | input | 8 | Weekday alarm, bit 7 enable |
| alm_enable | input | 1 | Global alarm enable |
| pulse_mode | input | 1 | 0 latched, 1 pulsed |
| freq_sel | input | 4 | Frequency-output code; nonzero inhibits alarm |
| clr_req | input | 1 | Software request to clear the flag |
| rd_busy | input | 1 | Status read in progress |
| rd_done | input | 1 | Strobe marking a completed status read |
| auto_clr | input | 1 | Auto-reset of the flag on a completed read |
| irq_n | output | 1 | Active-low interrupt, registered |
| alarm_flag | output | 1 | Alarm status flag |

## Verification
The bench builds the unit with PULSE_TICKS set to 6 and holds `tick_32k` high. With those settings, the full length of a pulsed interrupt can be counted cycle by cycle, along with its exact start edge and its recurrence on a second matching tick. The default of 8192 could not be covered that way. All other behaviour does not depend on the parameter, so the field masking, inhibit conditions, clear priority and read-race cases are exercised exactly as they run at the default.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NFIELD = 6;
  localparam int REG_W  = 8;
  localparam int VAL_W  = 7;
  typedef logic [REG_W-1:0] areg_t;
  typedef enum logic {MODE_LATCH = 1'b0, MODE_PULSE = 1'b1} alarm_mode_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int REG_W = 8,
  parameter int VAL_W = 7
) (
  input  logic [REG_W-1:0] alarm_reg,
  input  logic [REG_W-1:0] cur_val,
  output logic             fld_en,
  output logic             fld_ok
);
  // enable sits in the top bit; value below it
  assign fld_en = alarm_reg[REG_W-1];
  assign fld_ok = !fld_en || (alarm_reg[VAL_W-1:0] == cur_val[VAL_W-1:0]);
endmodule

// File: rtl/alarm_pulse_timer.sv
module alarm_pulse_timer #(
  parameter int PULSE_TICKS = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic busy
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(PULSE_TICKS);
    end else if (step && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/alarm_status_ctl.sv
module alarm_status_ctl (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr_req,
  input  logic rd_busy,
  input  logic rd_done,
  input  logic auto_clr,
  output logic flag
);
  logic fired_in_read;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag          <= 1'b0;
      fired_in_read <= 1'b0;
    end else begin
      if (hit) begin
        flag <= 1'b1;
      end else if (clr_req) begin
        flag <= 1'b0;
      end else if (rd_done && auto_clr && !fired_in_read) begin
        flag <= 1'b0;
      end

      if (rd_done) begin
        fired_in_read <= 1'b0;
      end else if (hit && rd_busy) begin
        fired_in_read <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/alarm_match_irq.sv
module alarm_match_irq
  import alarm_pkg::*;
#(
  parameter int PULSE_TICKS = 8192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1hz,
  input  logic       tick_32k,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_date,
  input  logic [7:0] cur_month,
  input  logic [7:0] cur_wday,
  input  logic [7:0] al_sec,
  input  logic [7:0] al_min,
  input  logic [7:0] al_hour,
  input  logic [7:0] al_date,
  input  logic [7:0] al_month,
  input  logic [7:0] al_wday,
  input  logic       alm_enable,
  input  logic       pulse_mode,
  input  logic [3:0] freq_sel,
  input  logic       clr_req,
  input  logic       rd_busy,
  input  logic       rd_done,
  input  logic       auto_clr,
  output logic       irq_n,
  output logic       alarm_flag
);
  areg_t cur_arr [NFIELD];
  areg_t al_arr  [NFIELD];
  logic [NFIELD-1:0] en_vec;
  logic [NFIELD-1:0] ok_vec;

  assign cur_arr[0] = cur_sec;   assign al_arr[0] = al_sec;
  assign cur_arr[1] = cur_min;   assign al_arr[1] = al_min;
  assign cur_arr[2] = cur_hour;  assign al_arr[2] = al_hour;
  assign cur_arr[3] = cur_date;  assign al_arr[3] = al_date;
  assign cur_arr[4] = cur_month; assign al_arr[4] = al_month;
  assign cur_arr[5] = cur_wday;  assign al_arr[5] = al_wday;

  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_fld
    alarm_field_cmp #(.REG_W(REG_W), .VAL_W(VAL_W)) u_cmp (
      .alarm_reg (al_arr[gi]),
      .cur_val   (cur_arr[gi]),
      .fld_en    (en_vec[gi]),
      .fld_ok    (ok_vec[gi])
    );
  end

  logic alarm_live;
  logic hit;
  logic pulse_busy;
  alarm_mode_e mode;

  assign mode       = alarm_mode_e'(pulse_mode);
  assign alarm_live = alm_enable && (freq_sel == 4'd0);
  assign hit        = tick_1hz && alarm_live && (|en_vec) && (&ok_vec);

  alarm_status_ctl u_status (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .clr_req  (clr_req),
    .rd_busy  (rd_busy),
    .rd_done  (rd_done),
    .auto_clr (auto_clr),
    .flag     (alarm_flag)
  );

  alarm_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk  (clk),
    .rst  (rst),
    .load (hit && mode == MODE_PULSE),
    .step (tick_32k),
    .busy (pulse_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
    end else if (mode == MODE_PULSE) begin
      irq_n <= !pulse_busy;
    end else begin
      irq_n <= !alarm_flag;
    end
  end
endmodule

// File: rtl/alarm_match_irq_chk.sv
module alarm_match_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic       alm_enable,
  input logic       pulse_mode,
  input logic [3:0] freq_sel,
  input logic       clr_req,
  input logic [7:0] al_sec,
  input logic [7:0] al_min,
  input logic [7:0] al_hour,
  input logic [7:0] al_date,
  input logic [7:0] al_month,
  input logic [7:0] al_wday,
  input logic       irq_n,
  input logic       alarm_flag
);
  logic none_en;
  assign none_en = !(al_sec[7] | al_min[7] | al_hour[7] | al_date[7] | al_month[7] | al_wday[7]);

  AST_SET_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag) |-> $past(tick_1hz)); // R3
  AST_NO_FIELDS_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    (none_en && !alarm_flag) |=> !alarm_flag); // R2
  AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!alm_enable && !alarm_flag) |=> !alarm_flag); // R4
  AST_FREQ_INHIBITS: assert property (@(posedge clk) disable iff (rst)
    ((freq_sel != 4'd0) && !alarm_flag) |=> !alarm_flag); // R5
  AST_LATCH_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!pulse_mode && $past(!pulse_mode)) |-> (irq_n == !$past(alarm_flag))); // R6
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !tick_1hz) |=> !alarm_flag); // R8
endmodule

bind alarm_match_irq alarm_match_irq_chk u_chk (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .alm_enable(alm_enable),
  .pulse_mode(pulse_mode), .freq_sel(freq_sel), .clr_req(clr_req),
  .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour), .al_date(al_date),
  .al_month(al_month), .al_wday(al_wday), .irq_n(irq_n), .alarm_flag(alarm_flag)
);

// File: tb/alarm_match_irq_bench.sv
module alarm_match_irq_bench;
  localparam int PT = 6;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1hz = 0, tick_32k = 1;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 8'h01, cur_month = 8'h01, cur_wday = 0;
  logic [7:0] al_sec = 0, al_min = 0, al_hour = 0, al_date = 0, al_month = 0, al_wday = 0;
  logic alm_enable = 0, pulse_mode = 0, clr_req = 0, rd_busy = 0, rd_done = 0, auto_clr = 0;
  logic [3:0] freq_sel = 0;
  logic irq_n, alarm_flag;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  alarm_match_irq #(.PULSE_TICKS(PT)) u_alarm_match_irq (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_32k(tick_32k),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .cur_month(cur_month), .cur_wday(cur_wday),
    .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour), .al_date(al_date),
    .al_month(al_month), .al_wday(al_wday),
    .alm_enable(alm_enable), .pulse_mode(pulse_mode), .freq_sel(freq_sel),
    .clr_req(clr_req), .rd_busy(rd_busy), .rd_done(rd_done), .auto_clr(auto_clr),
    .irq_n(irq_n), .alarm_flag(alarm_flag)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic one_tick();
    tick_1hz = 1; cyc(); tick_1hz = 0;
  endtask

  task automatic sw_clear();
    clr_req = 1; cyc(); clr_req = 0; cyc();
  endtask

  task automatic all_off();
    al_sec = 0; al_min = 0; al_hour = 0; al_date = 0; al_month = 0; al_wday = 0;
  endtask

  task automatic t_reset();
    chk("R6 reset irq_n", irq_n, 1);
    chk("R3 reset flag", alarm_flag, 0);
  endtask

  task automatic t_latch();
    alm_enable = 1; pulse_mode = 0; all_off();
    cur_sec = 8'h30; cur_min = 8'h15; al_sec = 8'hB0; al_min = 8'h95;
    cur_hour = 8'h07; al_hour = 8'h23;  // disabled, differs
    chk("R3 no tick no set", alarm_flag, 0);
    cyc(); cyc();
    chk("R3 no tick no set later", alarm_flag, 0);
    one_tick();
    chk("R1 R3 flag after tick", alarm_flag, 1);
    chk("R6 irq not yet low", irq_n, 1);
    cyc();
    chk("R6 irq low", irq_n, 0);
    cyc(); cyc();
    chk("R6 irq holds low", irq_n, 0);
    clr_req = 1; cyc(); clr_req = 0;
    chk("R8 flag cleared", alarm_flag, 0);
    chk("R6 irq still low one cycle", irq_n, 0);
    cyc();
    chk("R6 irq released", irq_n, 1);
  endtask

  task automatic t_mask();
    alm_enable = 1; pulse_mode = 0; all_off();
    cur_sec = 8'h30; cur_min = 8'h15;
    al_sec = 8'hB0; al_min = 8'h96;  // enabled minute differs
    one_tick(); cyc();
    chk("R1 enabled mismatch blocks", alarm_flag, 0);
    al_min = 8'h16;  // disabled now
    one_tick();
    chk("R1 disabled field ignored", alarm_flag, 1);
    sw_clear();
  endtask

  task automatic t_no_fields();
    alm_enable = 1; all_off();
    cur_sec = 0; cur_min = 0;
    one_tick(); cyc();
    chk("R2 no enables no alarm", alarm_flag, 0);
    chk("R2 irq idle", irq_n, 1);
  endtask

  task automatic t_inhibit();
    all_off(); cur_sec = 8'h45; al_sec = 8'hC5;
    alm_enable = 0;
    one_tick(); cyc();
    chk("R4 global off", alarm_flag, 0);
    alm_enable = 1; freq_sel = 4'd3;
    one_tick(); cyc();
    chk("R5 freq output inhibits", alarm_flag, 0);
    chk("R5 irq idle", irq_n, 1);
    freq_sel = 0;
    one_tick();
    chk("R5 alarm returns", alarm_flag, 1);
    sw_clear();
  endtask

  task automatic t_pulse();
    int lows;
    all_off(); alm_enable = 1; pulse_mode = 1;
    cur_sec = 8'h12; al_sec = 8'h92;
    for (int rep = 0; rep < 2; rep++) begin
      one_tick();
      chk("R7 flag set", alarm_flag, 1);
      chk("R7 irq starts next cycle", irq_n, 1);
      lows = 0;
      for (int k = 0; k < 3*PT; k++) begin
        cyc();
        if (irq_n == 0) lows++;
      end
      chk("R7 pulse length", lows, PT);
      chk("R7 irq back high", irq_n, 1);
      sw_clear();
    end
    pulse_mode = 0; cyc(); cyc();
  endtask

  task automatic t_clear_race();
    all_off(); alm_enable = 1; cur_sec = 8'h05; al_sec = 8'h85;
    tick_1hz = 1; clr_req = 1; cyc(); tick_1hz = 0; clr_req = 0;
    chk("R8 event beats clear", alarm_flag, 1);
    sw_clear();
    chk("R8 clear works", alarm_flag, 0);
  endtask

  task automatic t_autoclr();
    all_off(); alm_enable = 1; cur_sec = 8'h05; al_sec = 8'h85;
    one_tick();
    auto_clr = 0; rd_busy = 1; cyc(); rd_done = 1; cyc(); rd_done = 0; rd_busy = 0;
    chk("R9 no auto clear when off", alarm_flag, 1);
    auto_clr = 1; rd_busy = 1; cyc(); rd_done = 1; cyc(); rd_done = 0; rd_busy = 0;
    chk("R9 auto clear on read", alarm_flag, 0);
  endtask

  task automatic t_read_race();
    all_off(); alm_enable = 1; auto_clr = 1; cur_sec = 8'h05; al_sec = 8'h85;
    rd_busy = 1; cyc();
    one_tick();
    rd_done = 1; cyc(); rd_done = 0; rd_busy = 0;
    chk("R10 event during read keeps flag", alarm_flag, 1);
    rd_busy = 1; cyc(); rd_done = 1; cyc(); rd_done = 0; rd_busy = 0;
    chk("R10 next clean read clears", alarm_flag, 0);
    rd_busy = 1; rd_done = 1; tick_1hz = 1; cyc(); tick_1hz = 0; rd_done = 0; rd_busy = 0;
    chk("R10 event on done cycle keeps flag", alarm_flag, 1);
    auto_clr = 0; sw_clear();
  endtask

  initial begin
    fork
      begin
        @(negedge clk); cyc(); cyc();
        rst = 0; cyc();
        t_reset();
        t_latch();
        t_mask();
        t_no_fields();
        t_inhibit();
        t_pulse();
        t_clear_race();
        t_autoclr();
        t_read_race();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule